// File: doc/BRIEF.md
# Root hub port change bitmap generator

This block condenses the status of every downstream port of a root hub into the change bitmap that the hub reports to software on its status-change pipe. For each port it combines the connect, enable and over-current change flags from the port register file, a resume-timer-expired indication from the timer logic, and a per-port pending suspend-change flag that the block keeps itself. Any port with at least one of these conditions is marked in the bitmap. Bit 0 of the bitmap belongs to the hub and is never set here, so port `i` (counted from 0) lands on bit `i+1`.

A scan request captures the bitmap, the byte count and an any-change flag into output registers one cycle later, together with a one-cycle done strobe. The pending suspend-change flags are set by a per-port completion pulse from the suspend or resume sequencer, and they persist until software asks for that port's flag to be cleared.

Top module: `rhub_change_map`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `scan_done`, `any_change`, `byte_count`, `change_map` and `susp_pending` are all zero.
- R2: A scan marks flat bit `i+1` of `change_map` (bit `(i+1) mod 8` of byte `(i+1)/8`, byte k occupying bits `8k+7..8k`) when port `i` has its connect, enable or over-current change input set.
- R3: Bit 0 of `change_map` is never set, and bits above `NUM_PORTS` are never set.
- R4: A scan also marks port `i` when its pending suspend-change flag, as held before the cycle of the scan request, is set.
- R5: A scan also marks port `i` when its `resume_expired` input is set.
- R6: After a scan, `byte_count` equals `(NUM_PORTS+8)/8` and `any_change` is 1 when at least one port is marked; otherwise both are 0 and `change_map` is zero.
- R7: The outputs take the scan result on the clock edge that samples `scan_req`, `scan_done` is high for exactly the following cycle, and without a scan request `change_map`, `byte_count` and `any_change` hold their values.
- R8: A pulse on `susp_evt[i]` sets pending flag `i`; the flag is cleared only by `clr_req` with `clr_port == i`, and a `clr_port` value of `NUM_PORTS` or more changes no flag.
- R9: A set pulse and a clear request for the same port in the same cycle leave the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_req | input | 1 | Capture the change bitmap on this edge |
| conn_chg | input | NUM_PORTS | Per-port connect change flag |
| en_chg | input | NUM_PORTS | Per-port enable change flag |
| oc_chg | input | NUM_PORTS | Per-port over-current change flag |
| resume_expired | input | NUM_PORTS | Per-port resume timer expired |
| susp_evt | input | NUM_PORTS | Per-port suspend/resume completion pulse |
| clr_req | input | 1 | Clear one pending suspend-change flag |
| clr_port | input | IDX_W | 0-based port index for `clr_req` |
| change_map | output | 8*MAP_BYTES | Packed change bitmap, bit 0 reserved for the hub |
| byte_count | output | CNT_W | Reported bitmap length in bytes, 0 when nothing changed |
| any_change | output | 1 | At least one port is marked |
| scan_done | output | 1 | Outputs are valid for the last scan |
| susp_pending | output | NUM_PORTS | Pending suspend-change flags |

## Verification
The assertions assume nothing about how often scans arrive or how clear requests relate to the set pulses, so the stimulus mixes back-to-back scans, idle gaps and simultaneous set and clear on one port freely. The only input assumption is that the change and timer inputs are sampled levels with no meaning between edges; the bench changes every input just after the falling edge and keeps change inputs sparse so that both empty and full bitmaps occur. Clear indices are drawn over the whole index width, so values past the last port are exercised against the rule that they touch nothing.

// File: rtl/rhub_pkg.sv
package rhub_pkg;
  function automatic int map_bytes(input int nports);
    return (nports + 8) / 8;
  endfunction

  function automatic int idx_width(input int nports);
    return (nports > 1) ? $clog2(nports) : 1;
  endfunction

  function automatic int cnt_width(input int nbytes);
    return $clog2(nbytes + 1);
  endfunction
endpackage

// File: rtl/rhub_susp_flags.sv
module rhub_susp_flags #(
  parameter int NUM_PORTS = 10,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] set_pulse,
  input  logic                 clr_req,
  input  logic [IDX_W-1:0]     clr_port,
  output logic [NUM_PORTS-1:0] pend
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flag
    logic hit_clr;
    assign hit_clr = clr_req && (clr_port == IDX_W'(p));
    always_ff @(posedge clk) begin
      if (rst)
        pend[p] <= 1'b0;
      else if (set_pulse[p])
        pend[p] <= 1'b1;
      else if (hit_clr)
        pend[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/rhub_port_eval.sv
module rhub_port_eval #(
  parameter int NUM_PORTS = 10
) (
  input  logic [NUM_PORTS-1:0] conn_chg,
  input  logic [NUM_PORTS-1:0] en_chg,
  input  logic [NUM_PORTS-1:0] oc_chg,
  input  logic [NUM_PORTS-1:0] resume_expired,
  input  logic [NUM_PORTS-1:0] pend,
  output logic [NUM_PORTS-1:0] port_hit
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_eval
    logic reg_flags;
    assign reg_flags   = conn_chg[p] | en_chg[p] | oc_chg[p];
    assign port_hit[p] = reg_flags | pend[p] | resume_expired[p];
  end
endmodule

// File: rtl/rhub_bitmap_pack.sv
module rhub_bitmap_pack #(
  parameter int NUM_PORTS = 10,
  parameter int MAP_BYTES = 2,
  parameter int CNT_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scan_req,
  input  logic [NUM_PORTS-1:0]   port_hit,
  output logic [8*MAP_BYTES-1:0] change_map,
  output logic [CNT_W-1:0]       byte_count,
  output logic                   any_change,
  output logic                   scan_done
);
  localparam int MAP_W = 8 * MAP_BYTES;

  logic [MAP_W-1:0] map_next;
  logic             any_next;

  always_comb begin
    map_next = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      map_next[p+1] = port_hit[p];
  end

  assign any_next = |port_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      change_map <= '0;
      byte_count <= '0;
      any_change <= 1'b0;
      scan_done  <= 1'b0;
    end else begin
      scan_done <= scan_req;
      if (scan_req) begin
        change_map <= map_next;
        any_change <= any_next;
        byte_count <= any_next ? CNT_W'(MAP_BYTES) : '0;
      end
    end
  end
endmodule

// File: rtl/rhub_change_map.sv
module rhub_change_map #(
  parameter int NUM_PORTS = 10,
  localparam int MAP_BYTES = rhub_pkg::map_bytes(NUM_PORTS),
  localparam int IDX_W     = rhub_pkg::idx_width(NUM_PORTS),
  localparam int CNT_W     = rhub_pkg::cnt_width(MAP_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scan_req,
  input  logic [NUM_PORTS-1:0]   conn_chg,
  input  logic [NUM_PORTS-1:0]   en_chg,
  input  logic [NUM_PORTS-1:0]   oc_chg,
  input  logic [NUM_PORTS-1:0]   resume_expired,
  input  logic [NUM_PORTS-1:0]   susp_evt,
  input  logic                   clr_req,
  input  logic [IDX_W-1:0]       clr_port,
  output logic [8*MAP_BYTES-1:0] change_map,
  output logic [CNT_W-1:0]       byte_count,
  output logic                   any_change,
  output logic                   scan_done,
  output logic [NUM_PORTS-1:0]   susp_pending
);
  logic [NUM_PORTS-1:0] port_hit;

  rhub_susp_flags #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) flags_i (
    .clk(clk), .rst(rst), .set_pulse(susp_evt),
    .clr_req(clr_req), .clr_port(clr_port), .pend(susp_pending)
  );

  rhub_port_eval #(.NUM_PORTS(NUM_PORTS)) eval_i (
    .conn_chg(conn_chg), .en_chg(en_chg), .oc_chg(oc_chg),
    .resume_expired(resume_expired), .pend(susp_pending), .port_hit(port_hit)
  );

  rhub_bitmap_pack #(.NUM_PORTS(NUM_PORTS), .MAP_BYTES(MAP_BYTES), .CNT_W(CNT_W)) pack_i (
    .clk(clk), .rst(rst), .scan_req(scan_req), .port_hit(port_hit),
    .change_map(change_map), .byte_count(byte_count),
    .any_change(any_change), .scan_done(scan_done)
  );
endmodule

// File: rtl/rhub_change_map_chk.sv
module rhub_change_map_chk #(
  parameter int NUM_PORTS = 10,
  parameter int MAP_BYTES = 2,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scan_req,
  input logic [NUM_PORTS-1:0]   susp_evt,
  input logic                   clr_req,
  input logic [IDX_W-1:0]       clr_port,
  input logic [8*MAP_BYTES-1:0] change_map,
  input logic [CNT_W-1:0]       byte_count,
  input logic                   any_change,
  input logic                   scan_done,
  input logic [NUM_PORTS-1:0]   susp_pending
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!scan_done && !any_change && byte_count == '0 && change_map == '0 && susp_pending == '0));

  a_r3_bit0_clear: assert property (@(posedge clk) disable iff (rst)
    !change_map[0]);

  a_r6_count_full: assert property (@(posedge clk) disable iff (rst)
    (change_map != '0) |-> (any_change && byte_count == CNT_W'(MAP_BYTES)));

  a_r6_count_zero: assert property (@(posedge clk) disable iff (rst)
    (change_map == '0) |-> (!any_change && byte_count == '0));

  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    scan_req |=> scan_done);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !scan_req |=> (!scan_done && $stable(change_map) && $stable(byte_count)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic clr_hit;
    assign clr_hit = clr_req && (clr_port == IDX_W'(p));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      susp_evt[p] |=> susp_pending[p]);

    a_r8_only_clear: assert property (@(posedge clk) disable iff (rst)
      (!susp_evt[p] && !clr_hit) |=> $stable(susp_pending[p]));

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (!susp_evt[p] && clr_hit) |=> !susp_pending[p]);
  end
endmodule

bind rhub_change_map rhub_change_map_chk #(
  .NUM_PORTS(NUM_PORTS), .MAP_BYTES(MAP_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .scan_req(scan_req), .susp_evt(susp_evt),
  .clr_req(clr_req), .clr_port(clr_port), .change_map(change_map),
  .byte_count(byte_count), .any_change(any_change), .scan_done(scan_done),
  .susp_pending(susp_pending)
);

// File: tb/rhub_change_map_tb.sv
module rhub_change_map_tb_top;
  localparam int N     = 10;
  localparam int BYTES = (N + 8) / 8;
  localparam int MW    = 8 * BYTES;
  localparam int IW    = $clog2(N);
  localparam int CW    = $clog2(BYTES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_req = 1'b0;
  logic [N-1:0] conn_chg = '0, en_chg = '0, oc_chg = '0, resume_expired = '0, susp_evt = '0;
  logic clr_req = 1'b0;
  logic [IW-1:0] clr_port = '0;
  logic [MW-1:0] change_map;
  logic [CW-1:0] byte_count;
  logic any_change, scan_done;
  logic [N-1:0] susp_pending;

  int checks = 0;
  int errors = 0;
  logic [N-1:0]  pend_m = '0;
  logic [MW-1:0] exp_map = '0;

  always #5 clk = ~clk;

  rhub_change_map #(.NUM_PORTS(N)) dut_i (
    .clk(clk), .rst(rst), .scan_req(scan_req), .conn_chg(conn_chg), .en_chg(en_chg),
    .oc_chg(oc_chg), .resume_expired(resume_expired), .susp_evt(susp_evt),
    .clr_req(clr_req), .clr_port(clr_port), .change_map(change_map),
    .byte_count(byte_count), .any_change(any_change), .scan_done(scan_done),
    .susp_pending(susp_pending)
  );

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [MW-1:0] model_map();
    logic [MW-1:0] m = '0;
    for (int p = 0; p < N; p++)
      m[p+1] = conn_chg[p] | en_chg[p] | oc_chg[p] | pend_m[p] | resume_expired[p];
    return m;
  endfunction

  function automatic logic [N-1:0] model_pend();
    logic [N-1:0] q = pend_m;
    for (int p = 0; p < N; p++) begin
      if (susp_evt[p]) q[p] = 1'b1;
      else if (clr_req && int'(clr_port) == p) q[p] = 1'b0;
    end
    return q;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic did_scan = scan_req;
    if (scan_req) exp_map = model_map();
    pend_m = model_pend();
    @(posedge clk);
    @(negedge clk);
    chk("R7 done", 64'(scan_done), 64'(did_scan));
    chk("R8 pending", 64'(susp_pending), 64'(pend_m));
    chk("R2 R4 R5 map", 64'(change_map), 64'(exp_map));
    chk("R6 count", 64'(byte_count), (exp_map != '0) ? 64'(BYTES) : 64'd0);
    chk("R6 any", 64'(any_change), 64'(exp_map != '0));
    chk("R3 bit0", 64'(change_map[0]), 64'd0);
  endtask

  task automatic quiet();
    scan_req = 0; conn_chg = '0; en_chg = '0; oc_chg = '0;
    resume_expired = '0; susp_evt = '0; clr_req = 0; clr_port = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset map", 64'(change_map), 64'd0);
    chk("R1 reset done", 64'(scan_done), 64'd0);
    chk("R1 reset pend", 64'(susp_pending), 64'd0);
    rst = 0;
    tick();

    // R2: last port lands in byte 1 bit 2
    quiet(); conn_chg[N-1] = 1; scan_req = 1; tick();
    chk("R2 last port bit", 64'(change_map[N]), 64'd1);
    // R6: nothing changed -> zero length
    quiet(); scan_req = 1; tick();
    // R5 and R2 oc on port 0
    quiet(); resume_expired[3] = 1; oc_chg[0] = 1; en_chg[6] = 1; scan_req = 1; tick();
    // R7: outputs hold without scan while inputs move
    quiet(); conn_chg = '1; tick();
    // R9: set and clear same port same cycle
    quiet(); susp_evt[4] = 1; clr_req = 1; clr_port = 4; tick();
    // R4: scan with flag set sees it; flag stays
    quiet(); scan_req = 1; tick();
    // R8: out-of-range clear index ignored
    quiet(); clr_req = 1; clr_port = IW'(N + 2); tick();
    // R8: matching clear drops flag; same-cycle scan still sees old flag (R4)
    quiet(); clr_req = 1; clr_port = 4; scan_req = 1; tick();
    quiet(); scan_req = 1; tick();

    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3000; k++) begin
      quiet();
      scan_req = ($urandom % 3) == 0;
      for (int p = 0; p < N; p++) begin
        conn_chg[p]       = ($urandom % 12) == 0;
        en_chg[p]         = ($urandom % 15) == 0;
        oc_chg[p]         = ($urandom % 20) == 0;
        resume_expired[p] = ($urandom % 20) == 0;
        susp_evt[p]       = ($urandom % 10) == 0;
      end
      clr_req  = ($urandom % 2) == 0;
      clr_port = IW'($urandom);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule